// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Switch

This block selects one of two unrelated, free-running clocks and forwards it to a single output clock. The select input may change at any moment, with no timing relation to either clock. The output must never show a truncated high or low phase.

Each input clock has its own path. A select synchronizer and an enable flip-flop in that path both update on the falling edge of that clock. Each path's enable may only be set while the other path's enable is clear. The output is the OR of each clock ANDed with its enable.

When the select input changes, the active path first synchronizes the change and drops its enable while its clock is low. The other path then picks up the change through its own synchronizer. It sets its enable on a falling edge of its own clock, but only once it sees the first enable cleared. Between the two, the output rests low, and the new clock takes over from a low level.

Top module: `glitchless_clk_mux`

## Requirements
- R1: While rst_ni is low, both enables are clear and clk_o is held low.
- R2: After rst_ni is released, the clock named by sel_i drives clk_o. Here 0 selects clk_a_i and 1 selects clk_b_i.
- R3: Once sel_i has been steady long enough for a handover to finish, clk_o equals the selected clock at all times, and the unselected clock has no effect on clk_o.
- R4: The two enables are never set at the same time. An enable is set only if, on that clock's falling edge, the other enable was seen clear.
- R5: An enable changes only while its own clock is low, so a gated high phase is never cut short or started mid-phase.
- R6: After sel_i changes, the handover finishes within (SYNC_STAGES+1) periods of the old clock plus (SYNC_STAGES+2) periods of the new clock.
- R7: No high or low phase of clk_o is shorter than the shorter input half-period. This holds for any timing of sel_i, including pulses on sel_i that are shorter than a synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a_i | input | 1 | First source clock, chosen when sel_i is 0 |
| clk_b_i | input | 1 | Second source clock, chosen when sel_i is 1 |
| sel_i | input | 1 | Source choice, may be asynchronous to both clocks |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_o | output | 1 | Switched output clock |

## Verification
Four properties are checked on every relevant edge:
- the enables are mutually exclusive;
- a path only enables after seeing the other path disabled;
- each enable moves only while its own clock is low;
- the output is quiet during reset.

Other behaviours need the bench's scenarios:
- the minimum width of every output phase across many switch timings, including runt-length pulses on the select input;
- the handover latency bound;
- exact tracking of the selected clock after settling, which the bench samples between clock edges.

// File: rtl/gcm_pkg.sv
package gcm_pkg;
  localparam int unsigned SYNC_DEPTH_DEF = 2;

  typedef enum logic {
    SRC_A = 1'b0,
    SRC_B = 1'b1
  } src_sel_e;
endpackage

// File: rtl/gcm_sync.sv
// Falling-edge synchronizer, cleared by the asynchronous reset.
module gcm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gcm_leg.sv
// One source path: select sync, enable flop, and AND gate.
module gcm_leg #(
  parameter int unsigned       STAGES = 2,
  parameter gcm_pkg::src_sel_e OWN_ID = gcm_pkg::SRC_A
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_i,
  input  logic peer_en_i,
  output logic en_o,
  output logic gated_o
);
  logic want_raw;
  logic want_s;
  logic en_q;

  assign want_raw = (sel_i == OWN_ID);

  gcm_sync #(.STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (want_raw),
    .q_o   (want_s)
  );

  // Enable moves only on falling edge; blocked while peer still enabled.
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= want_s & ~peer_en_i;
  end

  assign en_o    = en_q;
  assign gated_o = clk_i & en_q;
endmodule

// File: rtl/glitchless_clk_mux.sv
module glitchless_clk_mux #(
  parameter int unsigned SYNC_STAGES = gcm_pkg::SYNC_DEPTH_DEF
) (
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_i,
  input  logic rst_ni,
  output logic clk_o
);
  logic en_a, en_b;
  logic gated_a, gated_b;

  gcm_leg #(.STAGES(SYNC_STAGES), .OWN_ID(gcm_pkg::SRC_A)) u_leg_a (
    .clk_i    (clk_a_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .peer_en_i(en_b),
    .en_o     (en_a),
    .gated_o  (gated_a)
  );

  gcm_leg #(.STAGES(SYNC_STAGES), .OWN_ID(gcm_pkg::SRC_B)) u_leg_b (
    .clk_i    (clk_b_i),
    .rst_ni   (rst_ni),
    .sel_i    (sel_i),
    .peer_en_i(en_a),
    .en_o     (en_b),
    .gated_o  (gated_b)
  );

  assign clk_o = gated_a | gated_b;
endmodule

// File: rtl/gcm_chk.sv
module gcm_chk (
  input logic clk_a_i,
  input logic clk_b_i,
  input logic rst_ni,
  input logic clk_o,
  input logic en_a,
  input logic en_b
);
  // R4
  excl_on_a_chk: assert property (@(negedge clk_a_i) disable iff (!rst_ni)
    !(en_a && en_b));

  // R4
  excl_on_b_chk: assert property (@(negedge clk_b_i) disable iff (!rst_ni)
    !(en_a && en_b));

  // R4
  handoff_a_chk: assert property (@(negedge clk_a_i) disable iff (!rst_ni)
    $rose(en_a) |-> !$past(en_b));

  // R4
  handoff_b_chk: assert property (@(negedge clk_b_i) disable iff (!rst_ni)
    $rose(en_b) |-> !$past(en_a));

  // R1
  reset_quiet_chk: assert property (@(posedge clk_a_i)
    !rst_ni |-> !clk_o);

  // R5
  always @(en_a) begin
    if (rst_ni) en_a_low_chk: assert (!clk_a_i);
  end

  // R5
  always @(en_b) begin
    if (rst_ni) en_b_low_chk: assert (!clk_b_i);
  end
endmodule

bind glitchless_clk_mux gcm_chk u_chk (
  .clk_a_i(clk_a_i),
  .clk_b_i(clk_b_i),
  .rst_ni (rst_ni),
  .clk_o  (clk_o),
  .en_a   (en_a),
  .en_b   (en_b)
);

// File: tb/sim_glitchless_clk_mux.sv
`timescale 1ns/100ps
module sim_glitchless_clk_mux;
  localparam real HALF_A   = 10.0;  // 50 MHz
  localparam real HALF_B   = 13.0;
  localparam real MIN_HALF = 10.0;
  localparam real SETTLE   = 170.0; // >= 3*20 + 4*26 for two sync stages

  logic clk_a = 1'b0, clk_b = 1'b0, sel = 1'b0, rst_ni = 1'b0;
  logic clk_o;
  int   vectors = 0, miscompares = 0;
  bit   done = 1'b0;
  realtime last_edge = 0.0;
  bit   armed = 1'b0;

  glitchless_clk_mux u0 (
    .clk_a_i(clk_a),
    .clk_b_i(clk_b),
    .sel_i  (sel),
    .rst_ni (rst_ni),
    .clk_o  (clk_o)
  );

  initial forever #(HALF_A) clk_a = ~clk_a;
  initial begin
    #3;
    forever #(HALF_B) clk_b = ~clk_b;
  end

  // R5 R7: every output phase measured
  always @(clk_o) begin
    if (rst_ni && armed) begin
      vectors++;
      if ($realtime - last_edge < MIN_HALF - 0.01) begin
        miscompares++;
        $display("FAIL R5 R7 phase width at %0t: actual %0.2f expected >= %0.2f",
                 $realtime, $realtime - last_edge, MIN_HALF);
      end
    end
    last_edge = $realtime;
    armed = rst_ni;
  end

  task automatic check_quiet(input int n);
    for (int i = 0; i < n; i++) begin
      vectors++;
      if (clk_o !== 1'b0) begin
        miscompares++;
        $display("FAIL R1 clk_o in reset at %0t: actual %b expected 0", $realtime, clk_o);
      end
      #1;
    end
  endtask

  // Sample at half-ns offsets, clear of all edges.
  task automatic follow(input int n, input string tag);
    logic exp;
    @(posedge clk_a);
    #0.5;
    for (int i = 0; i < n; i++) begin
      exp = sel ? clk_b : clk_a;
      vectors++;
      if (clk_o !== exp) begin
        miscompares++;
        $display("FAIL %s sel=%b at %0t: actual %b expected %b",
                 tag, sel, $realtime, clk_o, exp);
      end
      #1;
    end
  endtask

  initial begin
    #0.5;
    check_quiet(50);
    #4.8;
    rst_ni = 1'b1;
    #(SETTLE);
    follow(200, "R2");

    // Steady-state switches at varied phase offsets.
    for (int k = 0; k < 8; k++) begin
      @(posedge clk_a);
      #((k * 7 % 23) + 0.3);
      sel = ~sel;
      #(SETTLE);
      follow(150, "R3 R4 R6");
    end

    // Rapid, short select pulses.
    for (int k = 0; k < 60; k++) begin
      #((k * 11 % 37) + 1.3);
      sel = ~sel;
    end
    #(SETTLE);
    follow(200, "R3 R7");

    // Mid-run reset with B selected.
    @(posedge clk_b);
    #2.3;
    rst_ni = 1'b0;
    sel = 1'b1;
    #0.2;
    check_quiet(40);
    rst_ni = 1'b1;
    #(SETTLE);
    follow(200, "R2");

    sel = 1'b0;
    #(SETTLE);
    follow(200, "R3 R6");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired at %0t: actual running expected done", $realtime);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule